// File: doc/BRIEF.md
# Ethernet MAC Control and Interrupt Register File

This block is the software-visible register file of an Ethernet MAC. It holds the word-indexed control words for the address filter, the descriptor ring base addresses, the command word, the PHY management words, FIFO and frame-size settings, the interrupt enable mask and the current-address words. It drives the command bits and ring bases to the DMA engines, turns writes to two poll words into one-cycle kick pulses, and gathers event pulses from the transmit and receive engines into sticky write-one-to-clear status bits. The upper half of the status word drives a transmit interrupt line and the lower half drives a receive interrupt line, each gated by the enable mask.

Software can start a self-timed reset by setting bit 24 of the command word. For a fixed number of cycles the engines see a reset pulse, every read returns zero, writes and events are dropped, and every register is held at its default. The command bit then reads back as zero.

Top module: `mac_ctrl_regfile`

## Requirements
- R1: After reset, reads return 0xFFFFFFFC at indices 0x22 and 0x23, 0x00000101 at 0x27, 0x00000800 at 0x2A, 0x00007FFF at 0x2E, 0x00900000 at 0x26, and zero at every other index, including the filter words at 0x00 to 0x21.
- R2: Indices 0x00 to 0x36 other than 0x24, 0x28, 0x29 and 0x2C are plain 32-bit storage that read back what was written; indices above 0x36 ignore writes and read zero.
- R3: A write to index 0x24 with bit 24 set starts a software reset: `engine_rst` is high for exactly SWR_CYCLES cycles starting after that write edge, both interrupts stay low meanwhile, and afterwards every register holds its default value and index 0x24 bit 24 reads zero.
- R4: A read issued while `engine_rst` is high returns zero.
- R5: Writes issued while `engine_rst` is high have no effect.
- R6: An event pulse on `evt_i` sets the status bit (index 0x2C) in the same position for the implemented positions 24, 23, 18, 16 (transmit) and 11, 10, 9, 8, 4, 3, 0 (receive); the bit stays set until cleared; other positions read zero.
- R7: Writing index 0x2C clears each status bit whose write-data bit is 1 and leaves the others unchanged.
- R8: When an event and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R9: `tx_irq` is high when any status bit in 31:16 is set together with the same bit of the enable word (index 0x2B); `rx_irq` likewise for bits 15:0; both follow the status edge with no added delay.
- R10: A write to index 0x28 gives a one-cycle `tx_kick` pulse, a write to 0x29 a one-cycle `rx_kick` pulse; both indices read zero.
- R11: `tx_enable`, `rx_enable` and `long_frame_ok` reflect bits 8, 0 and 1 of index 0x24; `tx_ring_base` and `rx_ring_base` reflect indices 0x22 and 0x23.
- R12: `rdata` is loaded on the clock edge that samples `rd_en` and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid after the sampling edge |
| evt_i | input | 32 | Event pulses from the engines, status bit positions |
| tx_enable | output | 1 | Transmit engine on |
| rx_enable | output | 1 | Receive engine on |
| long_frame_ok | output | 1 | Accept frames over the size limit |
| tx_ring_base | output | 32 | Transmit descriptor ring base |
| rx_ring_base | output | 32 | Receive descriptor ring base |
| tx_kick | output | 1 | Transmit poll pulse |
| rx_kick | output | 1 | Receive poll pulse |
| engine_rst | output | 1 | Reset to the DMA engines during software reset |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |

## Verification
Every register, status bit, kick pulse and the engine reset change on the edge that samples the write or event, and the interrupt lines follow status in that same cycle; read data appears on the edge that samples the read strobe. The bench drives inputs on the falling edge, lets its behavioural model advance on the rising edge from the same inputs, and compares all outputs on the following falling edge, so each result is checked exactly one edge after its cause. Directed reads compare against fixed constants at that same point, and the reset window length is measured by counting falling edges with the engine reset high.

// File: rtl/mcr_pkg.sv
// Package: register layout, default values and status mask of the MAC
// register file. Assumes 32-bit words addressed by word index.
package mcr_pkg;
    parameter int unsigned WORD_W   = 32;
    parameter int unsigned ADDR_W   = 6;
    parameter int unsigned NUM_CAM  = 16;

    localparam int unsigned IDX_CAM_CMD  = 0;
    localparam int unsigned IDX_CAM_EN   = 1;
    localparam int unsigned IDX_CAM_BASE = 2;
    localparam int unsigned IDX_TX_RING  = IDX_CAM_BASE + 2 * NUM_CAM;
    localparam int unsigned IDX_RX_RING  = IDX_TX_RING + 1;
    localparam int unsigned IDX_CMD      = IDX_TX_RING + 2;
    localparam int unsigned IDX_PHY_DATA = IDX_TX_RING + 3;
    localparam int unsigned IDX_PHY_ADDR = IDX_TX_RING + 4;
    localparam int unsigned IDX_FIFO_THR = IDX_TX_RING + 5;
    localparam int unsigned IDX_TX_POLL  = IDX_TX_RING + 6;
    localparam int unsigned IDX_RX_POLL  = IDX_TX_RING + 7;
    localparam int unsigned IDX_RX_LIMIT = IDX_TX_RING + 8;
    localparam int unsigned IDX_IEN      = IDX_TX_RING + 9;
    localparam int unsigned IDX_STAT     = IDX_TX_RING + 10;
    localparam int unsigned IDX_MISSED   = IDX_TX_RING + 12;
    localparam int unsigned IDX_LAST     = IDX_TX_RING + 20;

    localparam int unsigned SWRST_BIT = 24;
    localparam int unsigned CMD_RX_ON = 0;
    localparam int unsigned CMD_LONG  = 1;
    localparam int unsigned CMD_TX_ON = 8;
    localparam int unsigned HALF_W    = WORD_W / 2;

    // Implemented status positions: transmit 24,23,18,16; receive 11,10,9,8,4,3,0.
    localparam logic [WORD_W-1:0] STAT_MASK = 32'h0185_0F19;

    // Default value of a register after any reset.
    function automatic logic [WORD_W-1:0] word_default(int unsigned idx);
        logic [WORD_W-1:0] v;
        v = '0;
        if (idx == IDX_TX_RING || idx == IDX_RX_RING) v = 32'hFFFF_FFFC;
        if (idx == IDX_FIFO_THR) v = 32'h0000_0101;
        if (idx == IDX_RX_LIMIT) v = 32'h0000_0800;
        if (idx == IDX_MISSED)   v = 32'h0000_7FFF;
        if (idx == IDX_PHY_ADDR) v = 32'h0090_0000;
        return v;
    endfunction

    // True for indices that are ordinary read/write storage.
    function automatic bit is_plain(int unsigned idx);
        return (idx <= IDX_LAST) && (idx != IDX_CMD) && (idx != IDX_STAT) &&
               (idx != IDX_TX_POLL) && (idx != IDX_RX_POLL);
    endfunction
endpackage

// File: rtl/mcr_swreset.sv
// Software reset timer. A request while idle starts a window of CYCLES
// cycles during which busy_o is high. Assumes CYCLES >= 1.
module mcr_swreset #(
    parameter int unsigned CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic busy_o,
    output logic start_o
);
    localparam int unsigned CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    assign busy_o  = (cnt_q != '0);
    assign start_o = req && !busy_o;

    // Load the window length on a start, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_o) begin
            cnt_q <= CNT_W'(CYCLES);
        end else if (busy_o) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/mcr_status.sv
// Sticky interrupt status with write-one-to-clear. Only positions set in
// MASK hold state; an event beats a clear in the same cycle. hold forces
// all bits to zero and drops events. Interrupt lines are combinational.
module mcr_status
    import mcr_pkg::*;
#(
    parameter logic [WORD_W-1:0] MASK = STAT_MASK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              clr_en,
    input  logic [WORD_W-1:0] clr_bits,
    input  logic [WORD_W-1:0] evt,
    input  logic [WORD_W-1:0] ien,
    output logic [WORD_W-1:0] stat_o,
    output logic              tx_irq,
    output logic              rx_irq
);
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        if (MASK[b]) begin : g_live
            logic s_q;
            // Set on event, clear on a one written, event has priority.
            always_ff @(posedge clk) begin
                if (!rst_n || hold) begin
                    s_q <= 1'b0;
                end else begin
                    s_q <= evt[b] | (s_q & ~(clr_en & clr_bits[b]));
                end
            end
            assign stat_o[b] = s_q;
        end else begin : g_dead
            assign stat_o[b] = 1'b0;
        end
    end

    assign tx_irq = |(stat_o[WORD_W-1:HALF_W] & ien[WORD_W-1:HALF_W]);
    assign rx_irq = |(stat_o[HALF_W-1:0] & ien[HALF_W-1:0]);
endmodule

// File: rtl/mcr_word_bank.sv
// Bank of COUNT consecutive register words starting at index BASE. Plain
// words are writable; the rest are constants at their default. hold
// forces every word to its default value.
module mcr_word_bank
    import mcr_pkg::*;
#(
    parameter int unsigned BASE  = 0,
    parameter int unsigned COUNT = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         hold,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [WORD_W-1:0]            wdata,
    output logic [COUNT-1:0][WORD_W-1:0] words_o
);
    for (genvar k = 0; k < COUNT; k++) begin : g_word
        localparam int unsigned      IDX = BASE + k;
        localparam logic [WORD_W-1:0] DEF = word_default(IDX);
        if (is_plain(IDX)) begin : g_rw
            logic [WORD_W-1:0] q;
            // Hold default during any reset, take write data on a hit.
            always_ff @(posedge clk) begin
                if (!rst_n || hold) begin
                    q <= DEF;
                end else if (wr_en && addr == ADDR_W'(IDX)) begin
                    q <= wdata;
                end
            end
            assign words_o[k] = q;
        end else begin : g_const
            assign words_o[k] = DEF;
        end
    end
endmodule

// File: rtl/mac_ctrl_regfile.sv
// MAC control and interrupt register file. Word-indexed read/write bus with
// one-cycle registered read data, self-timed software reset, sticky W1C
// status feeding separate transmit and receive interrupt lines, and poll
// pulses for the DMA engines. Assumes reads and writes are single-cycle.
module mac_ctrl_regfile
    import mcr_pkg::*;
#(
    parameter int unsigned SWR_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic [WORD_W-1:0] evt_i,
    output logic              tx_enable,
    output logic              rx_enable,
    output logic              long_frame_ok,
    output logic [WORD_W-1:0] tx_ring_base,
    output logic [WORD_W-1:0] rx_ring_base,
    output logic              tx_kick,
    output logic              rx_kick,
    output logic              engine_rst,
    output logic              tx_irq,
    output logic              rx_irq
);
    localparam int unsigned FLT_N = IDX_TX_RING;
    localparam int unsigned CTL_N = IDX_LAST - IDX_TX_RING + 1;

    logic busy, start, soft_clr, sw_req, hit_cmd, hit_stat;
    logic [FLT_N-1:0][WORD_W-1:0] flt_words;
    logic [CTL_N-1:0][WORD_W-1:0] ctl_words;
    logic [WORD_W-1:0] stat_q, cmd_q, ien, rd_word;

    assign hit_cmd  = wr_en && (addr == ADDR_W'(IDX_CMD));
    assign hit_stat = wr_en && (addr == ADDR_W'(IDX_STAT));
    assign sw_req   = hit_cmd && wdata[SWRST_BIT];
    assign soft_clr = start | busy;

    mcr_swreset #(.CYCLES(SWR_CYCLES)) u_swr (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (sw_req),
        .busy_o  (busy),
        .start_o (start)
    );

    mcr_word_bank #(.BASE(0), .COUNT(FLT_N)) u_flt (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (soft_clr),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .words_o (flt_words)
    );

    mcr_word_bank #(.BASE(IDX_TX_RING), .COUNT(CTL_N)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (soft_clr),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .words_o (ctl_words)
    );

    assign ien = ctl_words[IDX_IEN - IDX_TX_RING];

    mcr_status #(.MASK(STAT_MASK)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (soft_clr),
        .clr_en   (hit_stat),
        .clr_bits (wdata),
        .evt      (evt_i),
        .ien      (ien),
        .stat_o   (stat_q),
        .tx_irq   (tx_irq),
        .rx_irq   (rx_irq)
    );

    // Command word: reset bit is never stored, so it reads zero afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            cmd_q <= '0;
        end else if (hit_cmd) begin
            cmd_q <= wdata & ~(WORD_W'(1) << SWRST_BIT);
        end
    end

    // Select the addressed word for a read.
    always_comb begin
        rd_word = '0;
        for (int k = 0; k < FLT_N; k++) begin
            if (addr == ADDR_W'(k)) rd_word = flt_words[k];
        end
        for (int k = 0; k < CTL_N; k++) begin
            if (addr == ADDR_W'(IDX_TX_RING + k)) rd_word = ctl_words[k];
        end
        if (addr == ADDR_W'(IDX_CMD))  rd_word = cmd_q;
        if (addr == ADDR_W'(IDX_STAT)) rd_word = stat_q;
    end

    // Register read data; blank while the software reset runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= busy ? '0 : rd_word;
        end
    end

    // One-cycle poll pulses toward the engines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_kick <= 1'b0;
            rx_kick <= 1'b0;
        end else begin
            tx_kick <= !busy && wr_en && (addr == ADDR_W'(IDX_TX_POLL));
            rx_kick <= !busy && wr_en && (addr == ADDR_W'(IDX_RX_POLL));
        end
    end

    assign engine_rst    = busy;
    assign tx_enable     = cmd_q[CMD_TX_ON];
    assign rx_enable     = cmd_q[CMD_RX_ON];
    assign long_frame_ok = cmd_q[CMD_LONG];
    assign tx_ring_base  = ctl_words[0];
    assign rx_ring_base  = ctl_words[IDX_RX_RING - IDX_TX_RING];
endmodule

// File: rtl/mcr_checker.sv
// Assertion checker for mac_ctrl_regfile, attached by bind. Observes ports
// and the merged status word only.
module mcr_checker
    import mcr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [WORD_W-1:0] wdata,
    input logic [WORD_W-1:0] rdata,
    input logic [WORD_W-1:0] evt_i,
    input logic [WORD_W-1:0] stat_q,
    input logic              engine_rst,
    input logic              tx_irq,
    input logic              rx_irq,
    input logic              tx_kick,
    input logic              rx_kick
);
    logic start_wr;
    assign start_wr = wr_en && (addr == ADDR_W'(IDX_CMD)) && wdata[SWRST_BIT];

    assert_rd_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && engine_rst) |=> (rdata == '0));

    assert_rst_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(engine_rst) |-> $past(start_wr));

    assert_irq_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        engine_rst |-> (!tx_irq && !rx_irq));

    assert_evt_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(evt_i & STAT_MASK)) && !engine_rst && !start_wr) |=>
        ((stat_q & $past(evt_i & STAT_MASK)) == $past(evt_i & STAT_MASK)));

    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(IDX_STAT) && !engine_rst) |=>
        ((stat_q & $past(wdata & ~evt_i & STAT_MASK)) == '0));

    assert_tx_kick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_kick |-> $past(wr_en && addr == ADDR_W'(IDX_TX_POLL) && !engine_rst));

    assert_rx_kick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_kick |-> $past(wr_en && addr == ADDR_W'(IDX_RX_POLL) && !engine_rst));
endmodule

bind mac_ctrl_regfile mcr_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .evt_i      (evt_i),
    .stat_q     (stat_q),
    .engine_rst (engine_rst),
    .tx_irq     (tx_irq),
    .rx_irq     (rx_irq),
    .tx_kick    (tx_kick),
    .rx_kick    (rx_kick)
);

// File: tb/sim_mac_ctrl_regfile.sv
module sim_mac_ctrl_regfile;
    localparam int SWR = 16;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0, evt_i = '0;
    logic [31:0] rdata, tx_ring_base, rx_ring_base;
    logic tx_enable, rx_enable, long_frame_ok, tx_kick, rx_kick;
    logic engine_rst, tx_irq, rx_irq;

    int n_chk = 0, n_fail = 0, rst_hi = 0;
    bit done = 0, started = 0;

    always #4 clk = ~clk;

    mac_ctrl_regfile #(.SWR_CYCLES(SWR)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .evt_i(evt_i), .tx_enable(tx_enable),
        .rx_enable(rx_enable), .long_frame_ok(long_frame_ok),
        .tx_ring_base(tx_ring_base), .rx_ring_base(rx_ring_base),
        .tx_kick(tx_kick), .rx_kick(rx_kick), .engine_rst(engine_rst),
        .tx_irq(tx_irq), .rx_irq(rx_irq));

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_reg [0:63];
    logic [31:0] m_stat, m_rdata;
    int m_cnt;
    bit m_txk, m_rxk;

    function automatic void m_defaults();
        for (int i = 0; i < 64; i++) m_reg[i] = 32'h0;
        m_reg[6'h22] = 32'hFFFF_FFFC;
        m_reg[6'h23] = 32'hFFFF_FFFC;
        m_reg[6'h26] = 32'h0090_0000;
        m_reg[6'h27] = 32'h0000_0101;
        m_reg[6'h2A] = 32'h0000_0800;
        m_reg[6'h2E] = 32'h0000_7FFF;
        m_stat = 32'h0;
    endfunction

    function automatic logic [31:0] m_read(logic [5:0] a);
        if (a == 6'h2C) return m_stat;
        if (a == 6'h28 || a == 6'h29 || a > 6'h36) return 32'h0;
        return m_reg[a];
    endfunction

    always @(posedge clk) begin
        bit busy;
        started = 1;
        if (!rst_n) begin
            m_defaults();
            m_cnt = 0; m_rdata = 0; m_txk = 0; m_rxk = 0;
        end else begin
            busy = (m_cnt > 0);
            if (rd_en) m_rdata = busy ? 32'h0 : m_read(addr);
            m_txk = !busy && wr_en && addr == 6'h28;
            m_rxk = !busy && wr_en && addr == 6'h29;
            if (busy) begin
                m_cnt--;
                m_defaults();
            end else if (wr_en && addr == 6'h24 && wdata[24]) begin
                m_cnt = SWR;
                m_defaults();
            end else begin
                m_stat = (m_stat & ~((wr_en && addr == 6'h2C) ? wdata : 32'h0))
                         | (evt_i & 32'h0185_0F19);
                if (wr_en && addr <= 6'h36 && addr != 6'h2C && addr != 6'h28 && addr != 6'h29)
                    m_reg[addr] = (addr == 6'h24) ? (wdata & ~32'h0100_0000) : wdata;
            end
        end
    end

    // Compare every output against the model one edge after its cause.
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R12 rdata", rdata, m_rdata);
            chk("R9 tx_irq", {31'b0, tx_irq}, {31'b0, |(m_stat[31:16] & m_reg[6'h2B][31:16])});
            chk("R9 rx_irq", {31'b0, rx_irq}, {31'b0, |(m_stat[15:0] & m_reg[6'h2B][15:0])});
            chk("R10 kicks", {30'b0, tx_kick, rx_kick}, {30'b0, m_txk, m_rxk});
            chk("R3 engine_rst", {31'b0, engine_rst}, {31'b0, m_cnt > 0});
            chk("R11 cmd bits", {29'b0, tx_enable, rx_enable, long_frame_ok},
                {29'b0, m_reg[6'h24][8], m_reg[6'h24][0], m_reg[6'h24][1]});
            chk("R11 tx ring", tx_ring_base, m_reg[6'h22]);
            chk("R11 rx ring", rx_ring_base, m_reg[6'h23]);
            if (rst_n && engine_rst) rst_hi++;
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] v);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); rd_en = 0; v = rdata;
    endtask

    task automatic pulse(logic [31:0] e);
        @(negedge clk); evt_i = e;
        @(negedge clk); evt_i = 0;
    endtask

    task automatic finish_up();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired (R1..R12 incomplete)");
        finish_up();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 defaults
        rd(6'h22, v); chk("R1 tx ring default", v, 32'hFFFF_FFFC);
        rd(6'h23, v); chk("R1 rx ring default", v, 32'hFFFF_FFFC);
        rd(6'h27, v); chk("R1 fifo thr default", v, 32'h0000_0101);
        rd(6'h2A, v); chk("R1 rx limit default", v, 32'h0000_0800);
        rd(6'h2E, v); chk("R1 missed default", v, 32'h0000_7FFF);
        rd(6'h26, v); chk("R1 phy addr default", v, 32'h0090_0000);
        rd(6'h05, v); chk("R1 filter default", v, 32'h0);
        rd(6'h2C, v); chk("R1 status default", v, 32'h0);
        // R2 storage and unmapped indices
        wr(6'h07, 32'hA5A5_0001); rd(6'h07, v); chk("R2 filter word", v, 32'hA5A5_0001);
        wr(6'h33, 32'hFFFF_FFFF); rd(6'h33, v); chk("R2 current addr", v, 32'hFFFF_FFFF);
        wr(6'h3A, 32'h1);         rd(6'h3A, v); chk("R2 unmapped", v, 32'h0);
        // R12 hold while idle
        repeat (3) @(negedge clk); chk("R12 rdata hold", rdata, 32'h0);
        // R11 command bits and ring base
        wr(6'h24, 32'h0000_0103);
        chk("R11 enables", {29'b0, tx_enable, rx_enable, long_frame_ok}, 32'h7);
        wr(6'h22, 32'h0000_1000); chk("R11 ring out", tx_ring_base, 32'h0000_1000);
        // R10 poll pulse
        @(negedge clk); wr_en = 1; addr = 6'h28;
        @(negedge clk); wr_en = 0; chk("R10 tx kick high", {31'b0, tx_kick}, 32'h1);
        @(negedge clk); chk("R10 tx kick one cycle", {31'b0, tx_kick}, 32'h0);
        rd(6'h28, v); chk("R10 poll reads zero", v, 32'h0);
        // R9 / R6 events and interrupts
        wr(6'h2B, 32'h0005_0011);
        pulse(32'h0004_0000);
        chk("R9 tx irq on", {30'b0, tx_irq, rx_irq}, 32'h2);
        pulse(32'h0000_0010);
        chk("R9 rx irq on", {30'b0, tx_irq, rx_irq}, 32'h3);
        pulse(32'h4000_0020);
        rd(6'h2C, v); chk("R6 unimplemented ignored", v, 32'h0004_0010);
        pulse(32'h0080_0000);
        rd(6'h2C, v); chk("R6 sticky", v, 32'h0084_0010);
        // R7 clear transmit half only
        wr(6'h2C, v & 32'hFFFF_0000);
        rd(6'h2C, v); chk("R7 w1c upper", v, 32'h0000_0010);
        chk("R7 irqs after clear", {30'b0, tx_irq, rx_irq}, 32'h1);
        // R8 event beats clear
        @(negedge clk); wr_en = 1; addr = 6'h2C; wdata = 32'h10; evt_i = 32'h10;
        @(negedge clk); wr_en = 0; evt_i = 0;
        rd(6'h2C, v); chk("R8 event wins", v, 32'h0000_0010);
        wr(6'h2C, 32'h10); chk("R7 rx irq cleared", {31'b0, rx_irq}, 32'h0);
        // R3 / R4 / R5 software reset
        pulse(32'h0000_0001);
        wr(6'h24, 32'h0100_0000);
        chk("R3 engine reset high", {31'b0, engine_rst}, 32'h1);
        rd(6'h27, v); chk("R4 read blank", v, 32'h0);
        wr(6'h22, 32'h0000_2000);
        pulse(32'h0000_0010);
        while (engine_rst) @(negedge clk);
        chk("R3 reset length", rst_hi, SWR);
        rd(6'h22, v); chk("R5 write ignored", v, 32'hFFFF_FFFC);
        rd(6'h07, v); chk("R3 filter restored", v, 32'h0);
        rd(6'h24, v); chk("R3 reset bit cleared", v, 32'h0);
        rd(6'h2C, v); chk("R3 status cleared", v, 32'h0);
        rd(6'h2E, v); chk("R3 missed restored", v, 32'h0000_7FFF);
        repeat (2) @(negedge clk);
        finish_up();
    end
endmodule